// File: doc/BRIEF.md
# Legacy Address-Mode Compatibility Checker

This block sits next to a 32-bit processor core and polices a backward-compatible narrow-address mode. Two static straps select the configuration. The first, `cfg_prog32`, allows wide program modes. The second, `cfg_data32`, allows wide data addressing. The block holds the current processor mode field in a register. It filters every proposed write to that field, so a core strapped for narrow programs can never reach a wide mode.

For each memory access, the block raises at most one of two flags. It raises an address exception when a narrow data address strays above 64 MB. It raises a vector abort when a narrow-mode process touches the exception vector area with a data access while wide programs are enabled.

The block also produces a masked byte address from the program counter word address. It reports which mode the core should use to take an abort or undefined-instruction exception. All outputs are registered and appear one clock after the inputs that produce them.

Top module: `lam_compat_checker`

## Requirements
- R1: With `cfg_prog32` low, a mode write replaces only bits [1:0] of `mode_q`; bits [4:2] keep their previous value.
- R2: With `cfg_prog32` high, a mode write replaces all five bits of `mode_q`. The new value is visible one cycle after the write.
- R3: A synchronous reset sets `mode_q` to 5'b00011, clears both flags and `pc_addr`, and sets `exc_mode` to 5'b00011.
- R4: `exc_mode` is 5'b00011 when `cfg_prog32` is low. When it is high, `exc_mode` is 5'b11011 if `exc_undef` is 1 and 5'b10111 otherwise.
- R5: `pc_addr` is {6'b0, pc_word[23:0], 2'b00} when `cfg_prog32` is low, and {pc_word, 2'b00} when it is high.
- R6: `addr_exc` is raised when all of the following hold: `cfg_prog32` and `cfg_data32` are both low, the access is a data access (`acc_fetch`=0), and any of `acc_addr[31:26]` is 1.
- R7: `addr_exc` is never raised when `cfg_data32` is high, or for an instruction fetch.
- R8: `vec_abort` is raised for a data write (`acc_write`=1, `acc_fetch`=0) to a byte address from 0x00 to 0x1F, when `cfg_prog32` is 1 and `mode_q[4]` is 0.
- R9: Under the same conditions, a data read of addresses 0x00 to 0x1F raises `vec_abort` only if parameter `VEC_READ_ABORT` is 1. The default is 1.
- R10: `vec_abort` is never raised in the following cases: for an instruction fetch, when `mode_q[4]` is 1, or for an address of 0x20 or above.
- R11: At most one flag is high per access. A vector abort takes precedence over an address exception.
- R12: The flags describe the access presented one cycle earlier. Both flags are low in any cycle after one in which `acc_valid` was 0. An access that shares a cycle with a mode write is judged against the mode held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prog32 | input | 1 | Strap: wide program modes allowed |
| cfg_data32 | input | 1 | Strap: wide data addresses allowed |
| mode_wr_en | input | 1 | Proposed write to the mode field |
| mode_wr_val | input | 5 | Value proposed for the mode field |
| acc_valid | input | 1 | A memory access is presented |
| acc_addr | input | 32 | Byte address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| pc_word | input | 30 | Program counter as a word address |
| exc_undef | input | 1 | Pending exception is undefined-instruction (else abort) |
| mode_q | output | 5 | Filtered current mode field |
| addr_exc | output | 1 | Address exception for the previous access |
| vec_abort | output | 1 | Vector abort for the previous access |
| pc_addr | output | 32 | Masked program counter byte address |
| exc_mode | output | 5 | Mode in which to take the pending exception |

## Verification
Assertions check the following on every cycle:
- Upper mode bits stay frozen whenever wide programs are disabled.
- Fetches never abort.
- A wide data strap never yields an address exception.
- The two flags are never high together.
- The program counter is held below 64 MB in the narrow configuration.
- The exception mode is the narrow supervisor mode whenever wide programs are disabled.

Only the bench's sweep shows that the flags fire exactly at the vector and 64 MB boundaries. The sweep crosses both straps, every mode write value, and reads, writes and fetches at addresses on each side of those boundaries. The same sweep shows that a mode written in one cycle governs the accesses that follow it.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_SVC_NARROW = 5'b00011;
  localparam logic [MODE_W-1:0] MODE_ABT_WIDE   = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND_WIDE   = 5'b11011;

  typedef struct packed {
    logic vec_abort;
    logic addr_exc;
  } lam_flags_t;
endpackage

// File: rtl/lam_mode_reg.sv
module lam_mode_reg
  import lam_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              prog32,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_val,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] next_mode;

  always_comb begin
    next_mode = mode_q;
    if (wr_en) begin
      if (prog32) next_mode = wr_val;
      else        next_mode = {mode_q[MODE_W-1:2], wr_val[1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SVC_NARROW;
    else     mode_q <= next_mode;
  end

  // R1: upper mode bits frozen while wide programs are disabled
  assert_hi_bits_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    !prog32 |=> mode_q[MODE_W-1:2] == $past(mode_q[MODE_W-1:2]));
endmodule

// File: rtl/lam_access_check.sv
module lam_access_check
  import lam_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int NARROW_PC_W    = 24,
  parameter int VEC_BYTES      = 32,
  parameter bit VEC_READ_ABORT = 1'b1
)(
  input  logic              prog32,
  input  logic              data32,
  input  logic              mode_bit4,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              fetch,
  output lam_flags_t        flags
);
  localparam int VEC_W    = $clog2(VEC_BYTES);
  localparam int NARROW_W = NARROW_PC_W + 2;

  logic in_vec, above_narrow, access_qual, vec_hit, range_hit;

  assign in_vec       = ~|addr[ADDR_W-1:VEC_W];
  assign above_narrow = |addr[ADDR_W-1:NARROW_W];

  generate
    if (VEC_READ_ABORT) begin : g_rd_abort
      assign access_qual = 1'b1;
    end else begin : g_wr_only
      assign access_qual = write;
    end
  endgenerate

  assign vec_hit   = valid && !fetch && prog32 && !mode_bit4 && in_vec && access_qual;
  assign range_hit = valid && !fetch && !prog32 && !data32 && above_narrow;

  always_comb begin
    flags.vec_abort = vec_hit;
    flags.addr_exc  = range_hit && !vec_hit;
  end
endmodule

// File: rtl/lam_pc_mask.sv
module lam_pc_mask #(
  parameter int ADDR_W      = 32,
  parameter int NARROW_PC_W = 24
)(
  input  logic              prog32,
  input  logic [ADDR_W-3:0] pc_word,
  output logic [ADDR_W-1:0] pc_byte
);
  localparam int HI_W = ADDR_W - NARROW_PC_W - 2;

  assign pc_byte = prog32 ? {pc_word, 2'b00}
                          : {{HI_W{1'b0}}, pc_word[NARROW_PC_W-1:0], 2'b00};
endmodule

// File: rtl/lam_compat_checker.sv
module lam_compat_checker
  import lam_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int NARROW_PC_W    = 24,
  parameter int VEC_BYTES      = 32,
  parameter bit VEC_READ_ABORT = 1'b1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_prog32,
  input  logic              cfg_data32,
  input  logic              mode_wr_en,
  input  logic [4:0]        mode_wr_val,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic [ADDR_W-3:0] pc_word,
  input  logic              exc_undef,
  output logic [4:0]        mode_q,
  output logic              addr_exc,
  output logic              vec_abort,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [4:0]        exc_mode
);
  localparam int HI_W = ADDR_W - NARROW_PC_W - 2;

  lam_flags_t        flags_c;
  logic [ADDR_W-1:0] pc_c;
  logic [4:0]        exc_mode_c;

  lam_mode_reg mode_i (
    .clk(clk), .rst(rst), .prog32(cfg_prog32),
    .wr_en(mode_wr_en), .wr_val(mode_wr_val), .mode_q(mode_q)
  );

  lam_access_check #(
    .ADDR_W(ADDR_W), .NARROW_PC_W(NARROW_PC_W),
    .VEC_BYTES(VEC_BYTES), .VEC_READ_ABORT(VEC_READ_ABORT)
  ) chk_i (
    .prog32(cfg_prog32), .data32(cfg_data32), .mode_bit4(mode_q[4]),
    .valid(acc_valid), .addr(acc_addr), .write(acc_write),
    .fetch(acc_fetch), .flags(flags_c)
  );

  lam_pc_mask #(.ADDR_W(ADDR_W), .NARROW_PC_W(NARROW_PC_W)) pc_i (
    .prog32(cfg_prog32), .pc_word(pc_word), .pc_byte(pc_c)
  );

  assign exc_mode_c = !cfg_prog32 ? MODE_SVC_NARROW
                    : (exc_undef ? MODE_UND_WIDE : MODE_ABT_WIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_exc  <= 1'b0;
      vec_abort <= 1'b0;
      pc_addr   <= '0;
      exc_mode  <= MODE_SVC_NARROW;
    end else begin
      addr_exc  <= flags_c.addr_exc;
      vec_abort <= flags_c.vec_abort;
      pc_addr   <= pc_c;
      exc_mode  <= exc_mode_c;
    end
  end

  // R10: a fetch never produces a vector abort
  assert_fetch_no_vec_R10: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_fetch |=> !vec_abort);
  // R7: wide data strap suppresses the address exception
  assert_data32_no_exc_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_data32 |=> !addr_exc);
  // R11: never both flags at once
  assert_one_flag_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vec_abort, addr_exc}));
  // R12: an idle cycle yields no flags
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !vec_abort && !addr_exc);
  // R5: narrow program counter stays below 64 MB
  assert_pc_narrow_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_prog32 |=> pc_addr[ADDR_W-1:ADDR_W-HI_W] == '0);
  // R4: narrow configuration takes exceptions in narrow supervisor mode
  assert_exc_mode_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_prog32 |=> exc_mode == MODE_SVC_NARROW);
endmodule

// File: tb/lam_compat_checker_tb.sv
module lam_compat_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_prog32, cfg_data32, mode_wr_en;
  logic [4:0]  mode_wr_val;
  logic        acc_valid, acc_write, acc_fetch, exc_undef;
  logic [31:0] acc_addr;
  logic [29:0] pc_word;
  logic [4:0]  mode_q, exc_mode;
  logic        addr_exc, vec_abort;
  logic [31:0] pc_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lam_compat_checker dut_i (
    .clk(clk), .rst(rst), .cfg_prog32(cfg_prog32), .cfg_data32(cfg_data32),
    .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .pc_word(pc_word), .exc_undef(exc_undef), .mode_q(mode_q),
    .addr_exc(addr_exc), .vec_abort(vec_abort), .pc_addr(pc_addr),
    .exc_mode(exc_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_addr(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_001C;
      2: return 32'h0000_001F;
      3: return 32'h0000_0020;
      4: return 32'h03FF_FFFC;
      5: return 32'h0400_0000;
      6: return 32'h8000_0000;
      default: return 32'hFC00_0010;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp_mode;
    cfg_prog32 = 0; cfg_data32 = 0; mode_wr_en = 0; mode_wr_val = 0;
    acc_valid = 0; acc_addr = 0; acc_write = 0; acc_fetch = 0;
    pc_word = 0; exc_undef = 0; rst = 1;
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 2; d++) begin
        @(negedge clk);
        cfg_prog32 = p[0]; cfg_data32 = d[0]; rst = 1;
        acc_valid = 0; mode_wr_en = 0; pc_word = 30'h3FFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        // R3: reset state
        chk("R3 mode", {27'b0, mode_q}, 32'h3);
        chk("R3 flags", {30'b0, vec_abort, addr_exc}, 32'h0);
        chk("R3 pc", pc_addr, 32'h0);
        chk("R3 exc_mode", {27'b0, exc_mode}, 32'h3);
        rst = 0;
        exp_mode = 5'b00011;
        for (int mw = 0; mw < 32; mw++) begin
          // mode write cycle, no access
          mode_wr_en = 1; mode_wr_val = mw[4:0]; acc_valid = 0;
          acc_addr = 32'h0; // an idle vector address must not flag
          @(negedge clk);
          mode_wr_en = 0;
          exp_mode = p[0] ? mw[4:0] : {exp_mode[4:2], mw[1:0]};
          chk(p[0] ? "R2 mode write" : "R1 mode write", {27'b0, mode_q}, {27'b0, exp_mode});
          chk("R12 idle flags", {30'b0, vec_abort, addr_exc}, 32'h0);
          for (int k = 0; k < 8; k++) begin
            for (int w = 0; w < 2; w++) begin
              for (int f = 0; f < 2; f++) begin
                logic [31:0] a, exp_pc;
                logic ev, ea;
                a = pick_addr(k);
                acc_valid = 1; acc_addr = a; acc_write = w[0]; acc_fetch = f[0];
                exc_undef = w[0];
                pc_word = a[31:2] ^ {25'b0, mw[4:0]};
                @(negedge clk);
                ev = p[0] && !exp_mode[4] && (a < 32'h20) && !f[0];
                ea = !p[0] && !d[0] && !f[0] && (a[31:26] != 6'b0) && !ev;
                exp_pc = p[0] ? {pc_word, 2'b00} : {6'b0, pc_word[23:0], 2'b00};
                chk(f[0] ? "R10 fetch vec" : (w[0] ? "R8 vec write" : "R9 vec read"),
                    {31'b0, vec_abort}, {31'b0, ev});
                chk(f[0] ? "R7 fetch range" : (d[0] ? "R7 data32" : "R6 range"),
                    {31'b0, addr_exc}, {31'b0, ea});
                chk("R11 single flag", {31'b0, vec_abort & addr_exc}, 32'h0);
                chk("R5 pc", pc_addr, exp_pc);
                chk("R4 exc_mode", {27'b0, exc_mode},
                    {27'b0, p[0] ? (w[0] ? 5'b11011 : 5'b10111) : 5'b00011});
              end
            end
          end
          acc_valid = 0;
        end
        // R12: access in same cycle as mode write uses the old mode
        if (p[0]) begin
          mode_wr_en = 1; mode_wr_val = 5'b10011;
          @(negedge clk);
          mode_wr_val = 5'b00011; acc_valid = 1; acc_addr = 32'h4;
          acc_write = 1; acc_fetch = 0;
          @(negedge clk);
          mode_wr_en = 0; acc_valid = 0;
          chk("R12 old mode used", {31'b0, vec_abort}, 32'h0);
          acc_valid = 1;
          @(negedge clk);
          acc_valid = 0;
          chk("R12 new mode used", {31'b0, vec_abort}, 32'h1);
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule